// File: doc/BRIEF.md
# Multi-format serial audio receiver

This block turns a three-wire stereo PCM stream (a bit clock, a word clock that toggles once per channel, and a serial data line) into parallel signed samples. All three lines are treated as asynchronous. They pass through a synchroniser into the system-clock domain. The rising edges of the bit clock are then found by edge detection, and data and word clock are captured at each such edge. Samples are two's complement and arrive MSB first.

A 3-bit format code selects one of six framings: right-justified words of 16, 20 or 24 bits, a 24-bit left-justified word, and I2S-style words of 16 or 24 bits. A right-justified word ends on the last bit of its half-frame. A left-justified word starts on the first bit of its half-frame, and an I2S word starts one bit later. A swap input selects which word-clock level carries the left channel. Shorter words are left-aligned into the 24-bit outputs. Once a right word completes, both channel outputs update together and a one-cycle strobe is raised.

The control state machine has three states. It starts in ST_IDLE. It moves to ST_ALIGN on the first bit-clock rise, which records the word-clock level. It moves to ST_RUN on the first word-clock change. It stays in ST_RUN until reset. Words are only delivered in ST_RUN, so the partial half-frame that is in progress at reset is discarded.

Top module: `stereo_pcm_rx`

## Requirements
- R1: While reset is asserted and after its release, left_o and right_o are zero and valid_o is low until the first completed frame.
- R2: Format codes 000, 010 and 100 select right-justified words of 16, 20 and 24 bits. The word's LSB is the last bit captured before the word clock changes. Any earlier bits of that half-frame are ignored.
- R3: Code 110 selects a 24-bit left-justified word. Its MSB is the first bit captured with the new word-clock level, and the bits after the word are ignored.
- R4: Codes 001 and 011 select 16-bit and 24-bit I2S-style words. Their MSB is the second bit captured after the word-clock change, and the first bit is ignored.
- R5: With lr_swap_i low, the half-frame with the word clock high is the left channel. With lr_swap_i high, the half-frame with the word clock low is the left channel.
- R6: valid_o pulses for exactly one cycle after each right word completes, provided a left word completed before it. left_o and right_o change only in the cycle valid_o is high.
- R7: A 16-bit or 20-bit word appears in bits 23 down of the output, with the unused low bits zero. The sign therefore stays in bit 23.
- R8: The reserved codes 101 and 111 behave exactly as code 000.
- R9: Data is taken only at rising bit-clock edges. Bits before the first word-clock change after reset produce no word, so the first strobe carries the first complete left/right pair.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bclk_i | input | 1 | Serial bit clock (asynchronous) |
| lrclk_i | input | 1 | Word clock, one period per stereo frame (asynchronous) |
| sdata_i | input | 1 | Serial data, MSB first (asynchronous) |
| fmt_i | input | 3 | Framing code |
| lr_swap_i | input | 1 | Word-clock polarity select |
| left_o | output | 24 | Left sample, left-aligned two's complement |
| right_o | output | 24 | Right sample, left-aligned two's complement |
| valid_o | output | 1 | One-cycle strobe when a new pair is presented |

## Verification
The assertions rely on three conditions on the inputs:
- Each bit-clock level lasts at least three system clocks, so every rise is seen once and strobes cannot fall in adjacent cycles.
- Data and word clock change only near the falling bit-clock edge.
- fmt_i and lr_swap_i stay constant between resets, and each half-frame is long enough to hold the selected word plus any I2S delay.

The bench meets these conditions:
- It holds each bit-clock level for four system clocks and changes the data and word clock while the bit clock is low.
- It reapplies reset before every format change.
- It uses 32-bit half-frames.

It fills every ignored bit position with ones, so a decoder that takes bits from the wrong place shows up in the sample values.

// File: rtl/spr_pkg.sv
`timescale 1ns/1ps
package spr_pkg;

    localparam int WIDTH_BITS = 6;

    typedef enum logic [1:0] {
        ALIGN_RIGHT,
        ALIGN_LEFT,
        ALIGN_DELAYED
    } align_e;

    typedef struct packed {
        align_e                 align;
        logic [WIDTH_BITS-1:0]  width;
    } framing_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ALIGN,
        ST_RUN
    } rx_state_e;

    function automatic framing_t decode_framing(input logic [2:0] code);
        framing_t f;
        case (code)
            3'b010:  f = '{align: ALIGN_RIGHT,   width: WIDTH_BITS'(20)};
            3'b100:  f = '{align: ALIGN_RIGHT,   width: WIDTH_BITS'(24)};
            3'b110:  f = '{align: ALIGN_LEFT,    width: WIDTH_BITS'(24)};
            3'b001:  f = '{align: ALIGN_DELAYED, width: WIDTH_BITS'(16)};
            3'b011:  f = '{align: ALIGN_DELAYED, width: WIDTH_BITS'(24)};
            default: f = '{align: ALIGN_RIGHT,   width: WIDTH_BITS'(16)};
        endcase
        return f;
    endfunction

endpackage

// File: rtl/spr_sync.sv
`timescale 1ns/1ps
module spr_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [STAGES-1:0][WIDTH-1:0] stage_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q <= '0;
        else        stage_q <= {stage_q[STAGES-2:0], async_i};
    end

    assign sync_o = stage_q[STAGES-1];

    initial begin
        a_r9_stage_count: assert (STAGES >= 2);
    end
endmodule

// File: rtl/spr_shifter.sv
`timescale 1ns/1ps
module spr_shifter
    import spr_pkg::*;
#(
    parameter int SAMPLE_W = 24,
    parameter int CNT_W    = 7
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bit_en,
    input  logic                bit_i,
    input  logic                half_start,
    input  framing_t            cfg,
    output logic [SAMPLE_W-1:0] word_o
);
    logic [SAMPLE_W-1:0] tail_q, head_q, head_base, raw;
    logic [CNT_W-1:0]    pos_q, pos_cur, win_lo, win_hi;
    logic                in_win;

    always_comb begin
        pos_cur   = half_start ? '0 : pos_q;
        win_lo    = (cfg.align == ALIGN_DELAYED) ? CNT_W'(1) : '0;
        win_hi    = win_lo + CNT_W'(cfg.width);
        in_win    = (pos_cur >= win_lo) && (pos_cur < win_hi);
        head_base = half_start ? '0 : head_q;
        raw       = (cfg.align == ALIGN_RIGHT) ? tail_q : head_q;
        word_o    = raw << (WIDTH_BITS'(SAMPLE_W) - cfg.width);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tail_q <= '0;
            head_q <= '0;
            pos_q  <= '0;
        end else if (bit_en) begin
            tail_q <= {tail_q[SAMPLE_W-2:0], bit_i};
            head_q <= in_win ? {head_base[SAMPLE_W-2:0], bit_i} : head_base;
            pos_q  <= (pos_cur == {CNT_W{1'b1}}) ? pos_cur : pos_cur + 1'b1;
        end
    end

    // R9: a half-frame can only begin on a captured bit
    a_r9_start_on_edge: assert property (@(posedge clk) disable iff (!rst_n)
        half_start |-> bit_en);
    // R3: the first bit of a half-frame leaves the position counter at one
    a_r3_pos_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_en && half_start) |=> (pos_q == CNT_W'(1)));
endmodule

// File: rtl/stereo_pcm_rx.sv
`timescale 1ns/1ps
module stereo_pcm_rx
    import spr_pkg::*;
#(
    parameter int SAMPLE_W    = 24,
    parameter int SYNC_STAGES = 2,
    parameter int CNT_W       = 7
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bclk_i,
    input  logic                lrclk_i,
    input  logic                sdata_i,
    input  logic [2:0]          fmt_i,
    input  logic                lr_swap_i,
    output logic [SAMPLE_W-1:0] left_o,
    output logic [SAMPLE_W-1:0] right_o,
    output logic                valid_o
);
    logic [2:0]          sync_out;
    logic                bclk_s, lr_s, sd_s;
    logic                bclk_d_q, lr_last_q;
    logic                rise, change, ended_left;
    logic                have_left_q;
    logic [SAMPLE_W-1:0] left_pend_q, word;
    framing_t            cfg;
    rx_state_e           state_q, state_d;

    spr_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) sync_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({bclk_i, lrclk_i, sdata_i}),
        .sync_o  (sync_out)
    );

    assign {bclk_s, lr_s, sd_s} = sync_out;
    assign cfg        = decode_framing(fmt_i);
    assign rise       = bclk_s && !bclk_d_q;
    assign change     = rise && (lr_s != lr_last_q);
    assign ended_left = lr_last_q ^ lr_swap_i;

    spr_shifter #(.SAMPLE_W(SAMPLE_W), .CNT_W(CNT_W)) shifter_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .bit_en     (rise),
        .bit_i      (sd_s),
        .half_start (change),
        .cfg        (cfg),
        .word_o     (word)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bclk_d_q  <= 1'b0;
            lr_last_q <= 1'b0;
        end else begin
            bclk_d_q <= bclk_s;
            if (rise) lr_last_q <= lr_s;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (rise)   state_d = ST_ALIGN;
            ST_ALIGN: if (change) state_d = ST_RUN;
            ST_RUN:               state_d = ST_RUN;
            default:              state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            left_o      <= '0;
            right_o     <= '0;
            valid_o     <= 1'b0;
            left_pend_q <= '0;
            have_left_q <= 1'b0;
        end else begin
            valid_o <= 1'b0;
            if (state_q == ST_RUN && change) begin
                if (ended_left) begin
                    left_pend_q <= word;
                    have_left_q <= 1'b1;
                end else if (have_left_q) begin
                    left_o      <= left_pend_q;
                    right_o     <= word;
                    valid_o     <= 1'b1;
                    have_left_q <= 1'b0;
                end
            end
        end
    end

    a_r6_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o);
    a_r6_left_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_o |-> $stable(left_o));
    a_r6_right_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_o |-> $stable(right_o));
    a_r9_strobe_follows_edge: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> $past(rise));
    a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |-> !valid_o);
    a_r7_pad16: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && cfg.width == WIDTH_BITS'(16)) |->
        (left_o[SAMPLE_W-17:0] == '0 && right_o[SAMPLE_W-17:0] == '0));
endmodule

// File: tb/stereo_pcm_rx_tb_top.sv
`timescale 1ns/1ps
module stereo_pcm_rx_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bclk_i = 1'b0, lrclk_i = 1'b0, sdata_i = 1'b0;
    logic [2:0]  fmt_i = 3'b000;
    logic        lr_swap_i = 1'b0;
    logic [23:0] left_o, right_o;
    logic        valid_o;

    int errors = 0;
    int checks = 0;

    logic [23:0] cap_l [16];
    logic [23:0] cap_r [16];
    int          cap_n = 0;
    int          hold_err = 0, strobe_err = 0;
    logic [23:0] prev_l = '0, prev_r = '0;
    logic        prev_v = 1'b0;

    stereo_pcm_rx dut_i (
        .clk(clk), .rst_n(rst_n), .bclk_i(bclk_i), .lrclk_i(lrclk_i),
        .sdata_i(sdata_i), .fmt_i(fmt_i), .lr_swap_i(lr_swap_i),
        .left_o(left_o), .right_o(right_o), .valid_o(valid_o)
    );

    always #4 clk = ~clk;

    always @(negedge clk) begin
        if (rst_n) begin
            if (valid_o) begin
                if (cap_n < 16) begin
                    cap_l[cap_n] = left_o;
                    cap_r[cap_n] = right_o;
                end
                cap_n++;
                if (prev_v) strobe_err++;
            end else if (left_o != prev_l || right_o != prev_r) begin
                hold_err++;
            end
            prev_l = left_o;
            prev_r = right_o;
            prev_v = valid_o;
        end
    end

    task automatic check(input string req, input logic [23:0] act, input logic [23:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic send_bit(input logic lr, input logic d);
        bclk_i  = 1'b0;
        lrclk_i = lr;
        sdata_i = d;
        repeat (4) @(negedge clk);
        bclk_i = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    // mode: 0 right-justified, 1 left-justified, 2 I2S-style
    task automatic send_half(input logic lr, input logic [23:0] w, input int n, input int mode);
        for (int p = 0; p < 32; p++) begin
            logic b;
            b = 1'b1;
            if (mode == 0 && p >= 32 - n) b = w[n - 1 - (p - (32 - n))];
            if (mode == 1 && p < n)       b = w[n - 1 - p];
            if (mode == 2 && p >= 1 && p <= n) b = w[n - p];
            send_bit(lr, b);
        end
    endtask

    function automatic logic [23:0] mkword(input int n, input int s);
        logic [31:0] v;
        logic [31:0] mask;
        v    = (s * 32'h2545F491) ^ 32'h5A5A5A5A;
        mask = (32'h1 << n) - 1;
        v    = v & mask;
        v[n-1] = s[0];
        return v[23:0];
    endfunction

    task automatic do_reset(input logic [2:0] code, input logic pol);
        @(negedge clk);
        rst_n     = 1'b0;
        fmt_i     = code;
        lr_swap_i = pol;
        bclk_i    = 1'b0;
        lrclk_i   = pol;   // right-channel level
        sdata_i   = 1'b0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        cap_n = 0; hold_err = 0; strobe_err = 0;
        prev_l = '0; prev_r = '0; prev_v = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic run_format(input string req, input logic [2:0] code, input logic pol,
                              input int mode, input int n);
        logic [23:0] lw [3];
        logic [23:0] rw [3];
        logic        lv, rv;
        lv = ~pol;
        rv = pol;
        do_reset(code, pol);
        for (int k = 0; k < 3; k++) begin
            lw[k] = mkword(n, 7 * k + int'(code) * 3 + 1 + int'(pol));
            rw[k] = mkword(n, 11 * k + int'(code) * 5 + 2 + int'(pol));
        end
        send_half(rv, 24'hFFFFFF, 24, 1);          // preamble, discarded (R9)
        for (int k = 0; k < 3; k++) begin
            send_half(lv, lw[k], n, mode);
            send_half(rv, rw[k], n, mode);
        end
        for (int i = 0; i < 4; i++) send_bit(lv, 1'b1);
        repeat (12) @(negedge clk);
        check({req, " R9 strobe count"}, 24'(cap_n), 24'd3);
        for (int k = 0; k < 3 && k < cap_n; k++) begin
            check({req, " left"},  cap_l[k], lw[k] << (24 - n));
            check({req, " right"}, cap_r[k], rw[k] << (24 - n));
        end
        check({req, " R6 hold between strobes"}, 24'(hold_err), 24'd0);
        check({req, " R6 single-cycle strobe"}, 24'(strobe_err), 24'd0);
    endtask

    initial begin
        #(8 * 200000);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R1 reset left",  left_o,  24'h0);
        check("R1 reset right", right_o, 24'h0);
        check("R1 reset valid", 24'(valid_o), 24'h0);
        rst_n = 1'b1;
        repeat (20) @(negedge clk);
        check("R1 idle valid", 24'(valid_o), 24'h0);

        run_format("R2 R7 rj16",      3'b000, 1'b0, 0, 16);
        run_format("R2 R7 rj20",      3'b010, 1'b0, 0, 20);
        run_format("R2 rj24",         3'b100, 1'b0, 0, 24);
        run_format("R3 lj24",         3'b110, 1'b0, 1, 24);
        run_format("R4 R7 i2s16",     3'b001, 1'b0, 2, 16);
        run_format("R4 i2s24",        3'b011, 1'b0, 2, 24);
        run_format("R8 code101",      3'b101, 1'b0, 0, 16);
        run_format("R8 code111",      3'b111, 1'b0, 0, 16);
        run_format("R5 swap lj24",    3'b110, 1'b1, 1, 24);
        run_format("R5 swap rj16",    3'b000, 1'b1, 0, 16);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule